// File: doc/BRIEF.md
# Vector Strided Memory Address Sequencer

This block turns one vector load or store command into a series of per-element memory requests. A command gives a base address, an element size of 1, 2, 4 or 8 bytes, a stride mode, a register stride, a signedness flag, a store flag, a floating-point flag and a requested vector length. The sequencer first checks that the access is legal under the two enable inputs. For a legal command it issues one request per active lane, in lane order from 0, on a valid/ready channel. Each request carries the address, the lane index, the element size and the direction.

The address of the first element is the base. Each later element adds the increment. In unit-stride mode the increment is the element size in bytes. In strided mode it is the two's-complement stride value. All address arithmetic wraps modulo 2^64. The requested length is limited to the number of lanes the vector unit has. A one-cycle done pulse follows the last accepted request.

Load responses pass through an extension stage. It widens byte, halfword and word data to 64 bits with sign or zero fill, as the signedness of the last accepted command selects. It returns the data with its lane index, so the data can be written into the register of the matching micro-thread.

Top module: `vec_addr_seq`

## Requirements
- R1: The cycle after a legal command with a non-zero length is accepted, `req_valid_o` is high, `req_addr_o` equals the base address and `req_lane_o` is 0.
- R2: In unit-stride mode (`strided_i` = 0), each following request address is the previous one plus 1, 2, 4 or 8 bytes for size codes 0, 1, 2 and 3 respectively.
- R3: In strided mode (`strided_i` = 1), each following request address is the previous one plus `stride_i`, read as two's complement, modulo 2^64.
- R4: The block issues exactly min(`vlen_i`, MAX_LANES) requests, with lane indices 0, 1, 2 and so on in order. `done_o` is high for exactly the one cycle after the last handshake.
- R5: A legal command with `vlen_i` = 0 issues no request and raises `done_o` for one cycle, in the cycle after it is accepted.
- R6: A request moves on to the next element only on a cycle where `req_valid_o` and `req_ready_i` are both high. While the request is stalled, its address and lane stay stable.
- R7: A command is illegal in either of two cases. The first is size code 3 with `fp_elem_i` = 0 and `wide_int_en_i` = 0. The second is `fp_elem_i` = 1 with `fp_en_i` = 0. An illegal command raises `fault_o` for one cycle, in the cycle after it is accepted. It issues no request and raises no `done_o`.
- R8: A `start_i` that arrives while a sequence is in progress is ignored. The sequence in progress continues with its own addresses and length.
- R9: One cycle after `rsp_valid_i`, `wb_valid_o` is high and `wb_lane_o` equals the response lane. For size codes 0, 1 and 2, `wb_data_o` is the low 8, 16 or 32 bits of the response, widened with sign fill when `signed_i` was 1 and with zero fill when it was 0. For size code 3, `wb_data_o` is the response unchanged.
- R10: Every request carries the size code of its command on `req_size_o` and the store flag of its command on `req_write_o`.
- R11: After reset, `req_valid_o`, `done_o`, `fault_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Command strobe, accepted only when idle |
| base_i | input | 64 | Address of element 0 |
| stride_i | input | 64 | Register stride, two's complement |
| strided_i | input | 1 | 1 selects register stride, 0 selects unit stride |
| size_i | input | 2 | Element size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B |
| signed_i | input | 1 | Sign-extend load data (sizes 0 to 2) |
| fp_elem_i | input | 1 | Element is floating point |
| store_i | input | 1 | Command is a store |
| vlen_i | input | 16 | Requested vector length |
| wide_int_en_i | input | 1 | 64-bit integer elements enabled |
| fp_en_i | input | 1 | Floating-point elements enabled |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted by memory |
| req_addr_o | output | 64 | Element address |
| req_lane_o | output | 5 | Lane index of the element |
| req_size_o | output | 2 | Element size code |
| req_write_o | output | 1 | Request is a store |
| done_o | output | 1 | One-cycle pulse when the sequence is complete |
| fault_o | output | 1 | One-cycle pulse for an illegal command |
| rsp_valid_i | input | 1 | Load response valid |
| rsp_lane_i | input | 5 | Lane index of the load response |
| rsp_data_i | input | 64 | Raw load response data |
| wb_valid_o | output | 1 | Extended write-back valid |
| wb_lane_o | output | 5 | Lane for the write-back |
| wb_data_o | output | 64 | Sign- or zero-extended load data |

## Verification
The hardest case to bring about from the ports is a second `start_i` in the middle of a sequence. To be seen at all, it has to arrive while the sequence is still in progress. Otherwise it is simply a new command. The stimulus therefore holds `req_ready_i` low for some cycles at random, so that sequences run long. One directed command then strobes `start_i` with a different base after its first element. The bench checks that the addresses that follow still come from the first base. Address wrap past 2^64 and the clamping of `vlen_i` to MAX_LANES are also hard to hit at random. Each of them is therefore set up by a directed command: a base near the top of the address space, and a length of 40.

// File: rtl/vas_pkg.sv
// Shared types for the vector address sequencer.
// Assumes element sizes are powers of two from 1 to 8 bytes.
package vas_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } elem_size_e;

    // Per-command settings that outlive the start strobe.
    typedef struct packed {
        elem_size_e size;
        logic       sext;
        logic       write;
    } cmd_cfg_t;
endpackage

// File: rtl/vas_cmd_check.sv
// Command legality and increment selection.
// Purely combinational. Assumes size codes 0..3 mean 1, 2, 4 and 8 bytes.
module vas_cmd_check #(
    parameter int ADDR_W = 64
) (
    input  logic              strided_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  vas_pkg::elem_size_e size_i,
    input  logic              fp_elem_i,
    input  logic              wide_int_en_i,
    input  logic              fp_en_i,
    output logic              legal_o,
    output logic [ADDR_W-1:0] step_o
);
    import vas_pkg::*;

    logic fp_block;
    logic wide_block;

    // Decide whether the enables permit this element type.
    always_comb begin
        fp_block   = fp_elem_i && !fp_en_i;
        wide_block = !fp_elem_i && (size_i == SZ_DBL) && !wide_int_en_i;
        legal_o    = !fp_block && !wide_block;
    end

    // Pick the per-element address increment.
    always_comb begin
        if (strided_i) step_o = stride_i;
        else           step_o = ADDR_W'(1) << size_i;
    end
endmodule

// File: rtl/vas_issue_ctrl.sv
// Element issue controller: holds the running address and lane index,
// advances on each handshake, and raises done or fault pulses.
// Assumes the vector length has already been clamped to MAX_LANES.
module vas_issue_ctrl #(
    parameter int ADDR_W    = 64,
    parameter int MAX_LANES = 32,
    localparam int LANE_W   = $clog2(MAX_LANES),
    localparam int CNT_W    = $clog2(MAX_LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              legal_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] step_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              req_ready_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [LANE_W-1:0] req_lane_o,
    output logic              accept_o,
    output logic              done_o,
    output logic              fault_o
);
    logic              busy_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] step_q;
    logic [LANE_W-1:0] lane_q;
    logic [LANE_W-1:0] last_q;
    logic              fire;
    logic              at_last;

    // Handshake and end-of-sequence detection.
    always_comb begin
        accept_o = start_i && !busy_q;
        fire     = busy_q && req_ready_i;
        at_last  = (lane_q == last_q);
    end

    // Sequencing state: idle/busy, address, lane and the completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            addr_q  <= '0;
            step_q  <= '0;
            lane_q  <= '0;
            last_q  <= '0;
            done_o  <= 1'b0;
            fault_o <= 1'b0;
        end else begin
            done_o  <= 1'b0;
            fault_o <= 1'b0;
            if (accept_o) begin
                if (!legal_i) begin
                    fault_o <= 1'b1;
                end else if (count_i == '0) begin
                    done_o <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    addr_q <= base_i;
                    step_q <= step_i;
                    lane_q <= '0;
                    last_q <= LANE_W'(count_i - CNT_W'(1));
                end
            end else if (fire) begin
                addr_q <= addr_q + step_q;
                if (at_last) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    lane_q <= lane_q + LANE_W'(1);
                end
            end
        end
    end

    // Present the held request.
    always_comb begin
        req_valid_o = busy_q;
        req_addr_o  = addr_q;
        req_lane_o  = lane_q;
    end
endmodule

// File: rtl/vas_load_ext.sv
// Load write-back extension stage: one register of delay, widening each
// narrow element with sign or zero fill. One generate branch per size code.
// Assumes DATA_W is 64 so that size code 3 is a full-width element.
module vas_load_ext #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vas_pkg::elem_size_e size_i,
    input  logic              sext_i,
    input  logic              rsp_valid_i,
    input  logic [LANE_W-1:0] rsp_lane_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              wb_valid_o,
    output logic [LANE_W-1:0] wb_lane_o,
    output logic [DATA_W-1:0] wb_data_o
);
    localparam int NUM_SZ = 4;

    logic [DATA_W-1:0] cand [NUM_SZ];

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_width
        localparam int EW = 8 << g;
        if (EW >= DATA_W) begin : g_full
            // Full-width element passes through unchanged.
            always_comb cand[g] = rsp_data_i;
        end else begin : g_narrow
            // Fill upper bits with the element's top bit or with zero.
            always_comb begin
                cand[g] = {{(DATA_W-EW){sext_i && rsp_data_i[EW-1]}},
                           rsp_data_i[EW-1:0]};
            end
        end
    end

    // Register the selected width together with its lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid_o <= 1'b0;
            wb_lane_o  <= '0;
            wb_data_o  <= '0;
        end else begin
            wb_valid_o <= rsp_valid_i;
            if (rsp_valid_i) begin
                wb_lane_o <= rsp_lane_i;
                wb_data_o <= cand[size_i];
            end
        end
    end
endmodule

// File: rtl/vec_addr_seq.sv
// Vector strided memory address sequencer top.
// Validates a command, clamps its length, issues one request per lane and
// extends returned load data. Assumes start_i is ignored while busy.
module vec_addr_seq #(
    parameter int ADDR_W    = 64,
    parameter int MAX_LANES = 32,
    parameter int VLEN_W    = 16,
    localparam int LANE_W   = $clog2(MAX_LANES),
    localparam int CNT_W    = $clog2(MAX_LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic              strided_i,
    input  logic [1:0]        size_i,
    input  logic              signed_i,
    input  logic              fp_elem_i,
    input  logic              store_i,
    input  logic [VLEN_W-1:0] vlen_i,
    input  logic              wide_int_en_i,
    input  logic              fp_en_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [LANE_W-1:0] req_lane_o,
    output logic [1:0]        req_size_o,
    output logic              req_write_o,
    output logic              done_o,
    output logic              fault_o,
    input  logic              rsp_valid_i,
    input  logic [LANE_W-1:0] rsp_lane_i,
    input  logic [ADDR_W-1:0] rsp_data_i,
    output logic              wb_valid_o,
    output logic [LANE_W-1:0] wb_lane_o,
    output logic [ADDR_W-1:0] wb_data_o
);
    import vas_pkg::*;

    logic              legal;
    logic [ADDR_W-1:0] step;
    logic [CNT_W-1:0]  count;
    logic              accept;
    elem_size_e        size_e;
    cmd_cfg_t          cfg_q;

    // Map the raw size field onto the package type.
    always_comb size_e = elem_size_e'(size_i);

    // Limit the requested length to the lanes that exist.
    always_comb begin
        if (vlen_i > VLEN_W'(MAX_LANES)) count = CNT_W'(MAX_LANES);
        else                             count = CNT_W'(vlen_i);
    end

    vas_cmd_check #(.ADDR_W(ADDR_W)) u_check (
        .strided_i     (strided_i),
        .stride_i      (stride_i),
        .size_i        (size_e),
        .fp_elem_i     (fp_elem_i),
        .wide_int_en_i (wide_int_en_i),
        .fp_en_i       (fp_en_i),
        .legal_o       (legal),
        .step_o        (step)
    );

    vas_issue_ctrl #(.ADDR_W(ADDR_W), .MAX_LANES(MAX_LANES)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .legal_i     (legal),
        .base_i      (base_i),
        .step_i      (step),
        .count_i     (count),
        .req_ready_i (req_ready_i),
        .req_valid_o (req_valid_o),
        .req_addr_o  (req_addr_o),
        .req_lane_o  (req_lane_o),
        .accept_o    (accept),
        .done_o      (done_o),
        .fault_o     (fault_o)
    );

    // Keep size, signedness and direction of the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{size: SZ_BYTE, sext: 1'b0, write: 1'b0};
        end else if (accept) begin
            cfg_q <= '{size: size_e, sext: signed_i, write: store_i};
        end
    end

    // Request attributes follow the held command.
    always_comb begin
        req_size_o  = cfg_q.size;
        req_write_o = cfg_q.write;
    end

    vas_load_ext #(.DATA_W(ADDR_W), .LANE_W(LANE_W)) u_ext (
        .clk         (clk),
        .rst_n       (rst_n),
        .size_i      (cfg_q.size),
        .sext_i      (cfg_q.sext),
        .rsp_valid_i (rsp_valid_i),
        .rsp_lane_i  (rsp_lane_i),
        .rsp_data_i  (rsp_data_i),
        .wb_valid_o  (wb_valid_o),
        .wb_lane_o   (wb_lane_o),
        .wb_data_o   (wb_data_o)
    );
endmodule

// File: rtl/vas_chk.sv
// Protocol checker for vec_addr_seq, attached with bind.
// Observes ports only; all properties are disabled during reset.
module vas_chk #(
    parameter int ADDR_W = 64,
    parameter int LANE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [LANE_W-1:0] req_lane_o,
    input logic              done_o,
    input logic              fault_o,
    input logic              rsp_valid_i,
    input logic              wb_valid_o
);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=>
            req_valid_o && $stable(req_addr_o) && $stable(req_lane_o));

    // R4
    lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && req_ready_i |=>
            (req_valid_o && req_lane_o == LANE_W'($past(req_lane_o) + 1'b1))
            || (done_o && !req_valid_o));

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fault_o, req_valid_o}));

    // R9
    wb_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o == $past(rsp_valid_i));
endmodule

bind vec_addr_seq vas_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_vas_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .req_lane_o  (req_lane_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .rsp_valid_i (rsp_valid_i),
    .wb_valid_o  (wb_valid_o)
);

// File: tb/vec_addr_seq_test.sv
`timescale 1ns/1ps
module vec_addr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] base_i = '0;
    logic [63:0] stride_i = '0;
    logic        strided_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic        signed_i = 1'b0;
    logic        fp_elem_i = 1'b0;
    logic        store_i = 1'b0;
    logic [15:0] vlen_i = '0;
    logic        wide_int_en_i = 1'b1;
    logic        fp_en_i = 1'b1;
    logic        req_valid_o;
    logic        req_ready_i = 1'b0;
    logic [63:0] req_addr_o;
    logic [4:0]  req_lane_o;
    logic [1:0]  req_size_o;
    logic        req_write_o;
    logic        done_o;
    logic        fault_o;
    logic        rsp_valid_i = 1'b0;
    logic [4:0]  rsp_lane_i = '0;
    logic [63:0] rsp_data_i = '0;
    logic        wb_valid_o;
    logic [4:0]  wb_lane_o;
    logic [63:0] wb_data_o;

    int checks = 0;
    int errors = 0;
    logic [1:0] cur_size = 2'd0;
    logic       cur_sgn = 1'b0;

    always #2.5 clk = ~clk;

    vec_addr_seq uut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_ext(input logic [63:0] d, input logic [1:0] sz, input logic sg);
        case (sz)
            2'd0: return sg ? {{56{d[7]}}, d[7:0]} : {56'b0, d[7:0]};
            2'd1: return sg ? {{48{d[15]}}, d[15:0]} : {48'b0, d[15:0]};
            2'd2: return sg ? {{32{d[31]}}, d[31:0]} : {32'b0, d[31:0]};
            default: return d;
        endcase
    endfunction

    // Issue one command and follow it to completion against the model.
    task automatic run_cmd(input logic [63:0] base, input logic [63:0] stride, input logic strd,
                           input logic [1:0] sz, input logic sg, input logic fp, input logic wr,
                           input int vlen, input logic wide, input logic fpen, input bit inject);
        bit legal;
        int n;
        int idx;
        int guard;
        logic [63:0] step;
        logic [63:0] ea;
        bit rdy;
        base_i = base; stride_i = stride; strided_i = strd; size_i = sz; signed_i = sg;
        fp_elem_i = fp; store_i = wr; vlen_i = 16'(vlen); wide_int_en_i = wide; fp_en_i = fpen;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cur_size = sz; cur_sgn = sg;
        legal = !(fp && !fpen) && !(!fp && sz == 2'd3 && !wide);
        n = (vlen > 32) ? 32 : vlen;
        step = strd ? stride : (64'd1 << sz);
        if (!legal) begin
            check(fault_o == 1'b1, "R7 fault pulse", 64'(fault_o), 64'd1);
            check(!req_valid_o && !done_o, "R7 no request", 64'(req_valid_o), 64'd0);
            @(negedge clk);
            check(!fault_o && !req_valid_o && !done_o, "R7 quiet after fault", 64'(req_valid_o), 64'd0);
        end else if (n == 0) begin
            check(done_o && !req_valid_o, "R5 zero length done", 64'(done_o), 64'd1);
            @(negedge clk);
            check(!done_o && !req_valid_o, "R5 no request", 64'(req_valid_o), 64'd0);
        end else begin
            idx = 0; ea = base; guard = 0;
            while (!done_o && guard < 2000) begin
                if (idx >= n) begin
                    check(1'b0, "R4 extra request", 64'(idx), 64'(n));
                    break;
                end
                check(req_valid_o, "R4 valid", 64'(req_valid_o), 64'd1);
                if (idx == 0) check(req_addr_o == ea, "R1 first address", req_addr_o, ea);
                else if (strd) check(req_addr_o == ea, "R3 strided address", req_addr_o, ea);
                else check(req_addr_o == ea, "R2 unit address", req_addr_o, ea);
                check(req_lane_o == 5'(idx), "R4 lane", 64'(req_lane_o), 64'(idx));
                check(req_size_o == sz && req_write_o == wr, "R10 attributes",
                      {61'b0, req_write_o, req_size_o}, {61'b0, wr, sz});
                rdy = ($urandom_range(0, 3) != 0);
                req_ready_i = rdy;
                if (inject && idx == 1) begin
                    // R8: a second start mid-sequence must not disturb it
                    base_i = ~base; vlen_i = 16'd3; start_i = 1'b1;
                end
                @(negedge clk);
                start_i = 1'b0;
                if (rdy) begin
                    idx++;
                    ea = ea + step;
                end
                guard++;
            end
            req_ready_i = 1'b0;
            if (inject) check(idx == n, "R8 count after ignored start", 64'(idx), 64'(n));
            check(idx == n && done_o, "R4 element count", 64'(idx), 64'(n));
            @(negedge clk);
            check(!done_o && !req_valid_o, "R4 done is one cycle", 64'(done_o), 64'd0);
        end
    endtask

    // Send one load response and check the extended write-back.
    task automatic run_rsp(input logic [63:0] d, input logic [4:0] ln);
        logic [63:0] e;
        e = exp_ext(d, cur_size, cur_sgn);
        rsp_valid_i = 1'b1; rsp_data_i = d; rsp_lane_i = ln;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        check(wb_valid_o && wb_lane_o == ln, "R9 write-back lane", 64'(wb_lane_o), 64'(ln));
        check(wb_data_o == e, "R9 extension", wb_data_o, e);
        @(negedge clk);
        check(!wb_valid_o, "R9 single write-back", 64'(wb_valid_o), 64'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!req_valid_o && !done_o && !fault_o && !wb_valid_o, "R11 reset outputs",
              {60'b0, req_valid_o, done_o, fault_o, wb_valid_o}, 64'd0);

        // R2 unit stride for each size
        for (int s = 0; s < 4; s++)
            run_cmd(64'h1000, 64'd0, 1'b0, 2'(s), 1'b0, 1'b0, 1'(s & 1), 5, 1'b1, 1'b1, 1'b0);
        // R3 negative stride and wrap past the top of the address space
        run_cmd(64'h100, -64'sd24, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 12, 1'b1, 1'b1, 1'b0);
        run_cmd(64'hFFFF_FFFF_FFFF_FFF0, 64'd8, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 6, 1'b1, 1'b1, 1'b0);
        // R5 zero length; R4 clamp of 40 to 32 lanes
        run_cmd(64'h2000, 64'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b0);
        run_cmd(64'h3000, 64'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 40, 1'b1, 1'b1, 1'b0);
        // R7 both illegal cases, then legal 8-byte fp with wide ints off
        run_cmd(64'h4000, 64'd0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b1, 1'b0);
        run_cmd(64'h4000, 64'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 4, 1'b1, 1'b0, 1'b0);
        run_cmd(64'h4000, 64'd0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 4, 1'b0, 1'b1, 1'b0);
        // R8 start during a running sequence
        run_cmd(64'h5000, 64'd16, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 9, 1'b1, 1'b1, 1'b1);

        // R9 extension, every size and both signedness settings
        for (int s = 0; s < 4; s++) begin
            for (int g = 0; g < 2; g++) begin
                run_cmd(64'h0, 64'd0, 1'b0, 2'(s), 1'(g), 1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b0);
                run_rsp(64'h8123_4567_89AB_CDEF, 5'(s * 2 + g));
                run_rsp(64'h0000_0000_7F7F_7F7F, 5'(31 - s));
            end
        end

        // Constrained random commands and responses
        for (int k = 0; k < 40; k++) begin
            run_cmd({$urandom, $urandom}, 64'($signed($urandom_range(0, 4095)) - 2048),
                    1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                    ($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)), $urandom_range(0, 40),
                    ($urandom_range(0, 5) != 0), ($urandom_range(0, 5) != 0), ($urandom_range(0, 6) == 0));
            run_rsp({$urandom, $urandom}, 5'($urandom_range(0, 31)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule